// File: doc/BRIEF.md
# Vector Alternate-Format Legality Checker

This block sits beside the vector issue stage. It holds the vector type configuration written by software. For each vector floating-point operation presented to it, it decides in the same cycle whether the operation may issue. If it may, the block also tells the datapath which number format the operation's narrow operands use: native IEEE, BF16, or one of the two 8-bit formats (E4M3 and E5M2). One configuration bit, the alternate-format selector at bit 8, changes the meaning of the element width. At 16-bit elements it turns a fixed subset of operations into BF16 operations. At 8-bit elements it permits only the 8-bit integer conversions, in BF16 form. It has no legal meaning at 32-bit or wider elements.

The configuration write value has this layout: `[2:0]` group multiplier, `[5:3]` element width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits), `[6]` tail policy, `[7]` mask policy, `[8]` alternate-format selector. The stored copy shows the illegal flag in its most significant bit. For narrowing conversions, the 5-bit source-1 sub-opcode picks the 8-bit variants and their saturating forms. The block also repairs scalar floating-point operands for 16-bit elements. A scalar that is not properly NaN-boxed is replaced by the canonical NaN of the active 16-bit format.

Top module: `vfmt_legality`

## Requirements
- R1: On a write that is not reserved, `cfg_q` shows the written bits [8:0] from the cycle after the write edge, with all higher bits zero, including the illegal flag at bit XLEN-1. After reset, `cfg_q` holds only the illegal flag, and `cfg_bad` is 1.
- R2: A write is reserved when any of three conditions holds: the selector is 1 with a width code of 2 or more; the width code exceeds MAX_SEW_CODE (3 by default); or any bit from 9 to XLEN-1 is set. A reserved write stores only the illegal flag (bit XLEN-1 set, all other bits zero) and drives `cfg_bad` high from the next cycle.
- R3: While `cfg_bad` is 1, every valid operation gives `op_illegal` = 1. An operation code above the last defined class is illegal under any configuration.
- R4: With `op_valid` low, `op_illegal`, `op_fmt` and `op_sat` are all 0.
- R5: With the selector 0, every defined operation class is legal with `op_fmt` = 0 (native), except two cases. The 8-bit forms of R8 follow R8. The sub-opcodes of R10 follow R10.
- R6: With the selector 1 and 8-bit elements, two classes are legal with `op_fmt` = 1 (BF16): the widening integer-to-float conversion and the narrowing float-to-integer conversion (plain and toward-zero). All other classes are reserved, except the 8-bit forms of R8.
- R7: With the selector 1 and 16-bit elements, a fixed set of classes is legal with `op_fmt` = 1. The set covers add, subtract, reverse subtract, min/max, sign injection, slide-by-one, splat, merge, compares, multiply, fused multiply-add, widening add/sub/mul/multiply-add, both scalar moves, float-to-float widening and narrowing (including round-to-odd), reciprocal and reciprocal-square-root estimates, classify, and the three BF16 widen/narrow/multiply-accumulate classes. Divide, square root, reductions and all integer conversions are reserved.
- R8: With 8-bit elements, three forms are legal in either selector state: the 8-bit-to-BF16 widening class, the BF16-to-8-bit narrowing class, and the float-to-float narrowing class with sub-opcode 11001 or 11011. `op_fmt` is 2 (E4M3) when the selector is 0 and 3 (E5M2) when it is 1.
- R9: `op_sat` is 1 for a legal BF16-to-8-bit narrowing with sub-opcode 11111 and for a legal float-to-float narrowing with sub-opcode 11011. It is 0 for sub-opcode 11001 and for other sub-opcodes.
- R10: Sub-opcodes 11001 and 11011 on the float-to-float narrowing class, and 11111 on the BF16-to-8-bit narrowing class, are reserved at any element width other than 8 bits.
- R11: `scal_out` equals `scal_in[15:0]` when `scal_in` bits FLEN-1 to 16 are all ones. Otherwise it is 16'h7FC0 when the stored selector is 1 and 16'h7E00 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | XLEN | Configuration write value |
| cfg_q | output | XLEN | Stored configuration, illegal flag at bit XLEN-1 |
| cfg_bad | output | 1 | Stored configuration is illegal |
| op_valid | input | 1 | An operation is presented for checking |
| op_id | input | 6 | Operation class code (package enumeration) |
| op_vs1 | input | 5 | Source-1 sub-opcode field of the operation |
| op_illegal | output | 1 | Operation must raise illegal-instruction |
| op_fmt | output | 2 | Datapath format: 0 native, 1 BF16, 2 E4M3, 3 E5M2 |
| op_sat | output | 1 | Narrowing to 8 bits saturates instead of overflowing |
| scal_in | input | FLEN | Scalar floating-point operand |
| scal_out | output | 16 | Scalar operand after NaN-box repair for 16-bit elements |

## Verification
A wrong stored configuration shows on `cfg_q` and `cfg_bad` one cycle after the write that caused it. Because the decision logic reads only that stored copy, the same fault also reaches the operation outputs from that cycle. A wrong entry in the decision logic shows on `op_illegal`, `op_fmt` or `op_sat` in the same cycle the operation is presented. So each class is swept under every element width and selector state. A stale selector shows in `scal_out` as the wrong canonical NaN the moment an unboxed scalar is applied.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

   localparam int OP_W   = 6;
   localparam int VS1_W  = 5;
   localparam int CFG_W  = 9;
   localparam int HALF_W = 16;

   typedef enum logic [1:0] {
      FMT_NATIVE = 2'd0,
      FMT_BF16   = 2'd1,
      FMT_E4M3   = 2'd2,
      FMT_E5M2   = 2'd3
   } fmt_e;

   typedef enum logic [OP_W-1:0] {
      OP_ADD        = 6'd0,
      OP_SUB        = 6'd1,
      OP_MINMAX     = 6'd2,
      OP_SGNJ       = 6'd3,
      OP_SLIDE1     = 6'd4,
      OP_SPLAT      = 6'd5,
      OP_MERGE      = 6'd6,
      OP_CMP        = 6'd7,
      OP_MUL        = 6'd8,
      OP_RSUB       = 6'd9,
      OP_FMA        = 6'd10,
      OP_WADDSUB    = 6'd11,
      OP_WMUL       = 6'd12,
      OP_WFMA       = 6'd13,
      OP_MV_TO_ELEM = 6'd14,
      OP_MV_TO_SCAL = 6'd15,
      OP_WCVT_FF    = 6'd16,
      OP_NCVT_FF    = 6'd17,
      OP_NCVT_ROD   = 6'd18,
      OP_RSQRT_EST  = 6'd19,
      OP_RECIP_EST  = 6'd20,
      OP_CLASS      = 6'd21,
      OP_WMACC_BF   = 6'd22,
      OP_WCVT_BF    = 6'd23,
      OP_NCVT_BF    = 6'd24,
      OP_DIV        = 6'd25,
      OP_SQRT       = 6'd26,
      OP_REDUCE     = 6'd27,
      OP_WCVT_IF    = 6'd28,
      OP_NCVT_FI    = 6'd29,
      OP_CVT_IF     = 6'd30
   } op_e;

   localparam logic [OP_W-1:0] OP_LAST = OP_CVT_IF;

   localparam logic [VS1_W-1:0] SUB_Q_PLAIN = 5'b11001;
   localparam logic [VS1_W-1:0] SUB_Q_SAT   = 5'b11011;
   localparam logic [VS1_W-1:0] SUB_BF_SAT  = 5'b11111;

   localparam logic [HALF_W-1:0] CNAN_BF16 = 16'h7FC0;
   localparam logic [HALF_W-1:0] CNAN_FP16 = 16'h7E00;

   typedef struct packed {
      logic       alt;
      logic       mask_pol;
      logic       tail_pol;
      logic [2:0] sew;
      logic [2:0] lmul;
   } cfg_t;

endpackage

// File: rtl/vfmt_cfg_reg.sv
module vfmt_cfg_reg
   import vfmt_pkg::*;
#(
   parameter int XLEN         = 64,
   parameter int MAX_SEW_CODE = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] cfg_word,
   output cfg_t            cfg_fld,
   output logic            cfg_bad
);

   localparam int PAD_W = XLEN - CFG_W - 1;

   cfg_t wr_fld;
   logic wr_rsv;
   cfg_t fld_q;
   logic bad_q;

   assign wr_fld = cfg_t'(wr_data[CFG_W-1:0]);

   always_comb begin
      wr_rsv = 1'b0;
      if (wr_fld.alt && (wr_fld.sew >= 3'd2))   wr_rsv = 1'b1;
      if (wr_fld.sew > 3'(MAX_SEW_CODE))        wr_rsv = 1'b1;
      if (|wr_data[XLEN-1:CFG_W])               wr_rsv = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bad_q <= 1'b1;
         fld_q <= '0;
      end else if (wr_en) begin
         bad_q <= wr_rsv;
         fld_q <= wr_rsv ? cfg_t'('0) : wr_fld;
      end
   end

   assign cfg_word = {bad_q, {PAD_W{1'b0}}, fld_q};
   assign cfg_fld  = fld_q;
   assign cfg_bad  = bad_q;

endmodule

// File: rtl/vfmt_op_decode.sv
module vfmt_op_decode
   import vfmt_pkg::*;
#(
   parameter bit OFP8_EN = 1'b1
) (
   input  cfg_t             cfg_fld,
   input  logic             cfg_bad,
   input  logic             op_valid,
   input  logic [OP_W-1:0]  op_id,
   input  logic [VS1_W-1:0] op_vs1,
   output logic             op_illegal,
   output fmt_e             op_fmt,
   output logic             op_sat
);

   op_e  op;
   logic ofp8_allowed;
   logic known, is_e8, is_e16;
   logic q_code, bf_sat_code, sat_code, special_code, ofp8_form;
   logic bf16_set, int8_set;

   generate
      if (OFP8_EN) begin : g_ofp8_on
         assign ofp8_allowed = 1'b1;
      end else begin : g_ofp8_off
         assign ofp8_allowed = 1'b0;
      end
   endgenerate

   assign op = op_e'(op_id);

   always_comb begin
      known        = (op_id <= OP_LAST);
      is_e8        = (cfg_fld.sew == 3'd0);
      is_e16       = (cfg_fld.sew == 3'd1);
      q_code       = (op == OP_NCVT_FF) &&
                     ((op_vs1 == SUB_Q_PLAIN) || (op_vs1 == SUB_Q_SAT));
      bf_sat_code  = (op == OP_NCVT_BF) && (op_vs1 == SUB_BF_SAT);
      sat_code     = ((op == OP_NCVT_FF) && (op_vs1 == SUB_Q_SAT)) || bf_sat_code;
      special_code = q_code || bf_sat_code;
      ofp8_form    = is_e8 && ((op == OP_WCVT_BF) || (op == OP_NCVT_BF) || q_code);
      int8_set     = (op == OP_WCVT_IF) || (op == OP_NCVT_FI);
      bf16_set     = op inside {OP_ADD, OP_SUB, OP_MINMAX, OP_SGNJ, OP_SLIDE1,
                                OP_SPLAT, OP_MERGE, OP_CMP, OP_MUL, OP_RSUB,
                                OP_FMA, OP_WADDSUB, OP_WMUL, OP_WFMA,
                                OP_MV_TO_ELEM, OP_MV_TO_SCAL, OP_WCVT_FF,
                                OP_NCVT_FF, OP_NCVT_ROD, OP_RSQRT_EST,
                                OP_RECIP_EST, OP_CLASS, OP_WMACC_BF,
                                OP_WCVT_BF, OP_NCVT_BF};

      op_illegal = 1'b0;
      op_fmt     = FMT_NATIVE;
      op_sat     = 1'b0;
      if (!op_valid) begin
         op_illegal = 1'b0;
      end else if (cfg_bad || !known) begin
         op_illegal = 1'b1;
      end else if (ofp8_form) begin
         if (ofp8_allowed) begin
            op_fmt = cfg_fld.alt ? FMT_E5M2 : FMT_E4M3;
            op_sat = sat_code;
         end else begin
            op_illegal = 1'b1;
         end
      end else if (special_code) begin
         op_illegal = 1'b1;
      end else if (!cfg_fld.alt) begin
         op_fmt = FMT_NATIVE;
      end else if (is_e8) begin
         if (int8_set) op_fmt = FMT_BF16;
         else          op_illegal = 1'b1;
      end else if (is_e16) begin
         if (bf16_set) op_fmt = FMT_BF16;
         else          op_illegal = 1'b1;
      end else begin
         op_illegal = 1'b1;
      end
   end

endmodule

// File: rtl/vfmt_nanbox.sv
module vfmt_nanbox
   import vfmt_pkg::*;
#(
   parameter int FLEN = 64
) (
   input  logic [FLEN-1:0]   scal_in,
   input  logic              alt,
   output logic [HALF_W-1:0] scal_out
);

   generate
      if (FLEN > HALF_W) begin : g_boxed
         logic boxed;
         assign boxed    = &scal_in[FLEN-1:HALF_W];
         assign scal_out = boxed ? scal_in[HALF_W-1:0]
                                 : (alt ? CNAN_BF16 : CNAN_FP16);
      end else begin : g_flat
         logic unused_alt;
         assign unused_alt = alt;
         assign scal_out   = scal_in[HALF_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/vfmt_legality.sv
module vfmt_legality
   import vfmt_pkg::*;
#(
   parameter int XLEN         = 64,
   parameter int FLEN         = 64,
   parameter int MAX_SEW_CODE = 3,
   parameter bit OFP8_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [XLEN-1:0]   cfg_wr_data,
   output logic [XLEN-1:0]   cfg_q,
   output logic              cfg_bad,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_id,
   input  logic [VS1_W-1:0]  op_vs1,
   output logic              op_illegal,
   output logic [1:0]        op_fmt,
   output logic              op_sat,
   input  logic [FLEN-1:0]   scal_in,
   output logic [HALF_W-1:0] scal_out
);

   generate
      if (XLEN < 16) begin : g_xlen_chk
         $error("vfmt_legality: XLEN must be at least 16");
      end
      if (FLEN < HALF_W) begin : g_flen_chk
         $error("vfmt_legality: FLEN must be at least 16");
      end
      if ((MAX_SEW_CODE < 1) || (MAX_SEW_CODE > 7)) begin : g_sew_chk
         $error("vfmt_legality: MAX_SEW_CODE must lie in 1..7");
      end
   endgenerate

   cfg_t cfg_fld;
   fmt_e fmt_w;

   vfmt_cfg_reg #(
      .XLEN         (XLEN),
      .MAX_SEW_CODE (MAX_SEW_CODE)
   ) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .wr_data  (cfg_wr_data),
      .cfg_word (cfg_q),
      .cfg_fld  (cfg_fld),
      .cfg_bad  (cfg_bad)
   );

   vfmt_op_decode #(
      .OFP8_EN (OFP8_EN)
   ) dec_i (
      .cfg_fld    (cfg_fld),
      .cfg_bad    (cfg_bad),
      .op_valid   (op_valid),
      .op_id      (op_id),
      .op_vs1     (op_vs1),
      .op_illegal (op_illegal),
      .op_fmt     (fmt_w),
      .op_sat     (op_sat)
   );

   assign op_fmt = fmt_w;

   vfmt_nanbox #(
      .FLEN (FLEN)
   ) box_i (
      .scal_in  (scal_in),
      .alt      (cfg_fld.alt),
      .scal_out (scal_out)
   );

endmodule

// File: rtl/vfmt_legality_chk.sv
module vfmt_legality_chk #(
   parameter int XLEN = 64,
   parameter int FLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_wr_en,
   input logic [XLEN-1:0] cfg_wr_data,
   input logic [XLEN-1:0] cfg_q,
   input logic            cfg_bad,
   input logic            op_valid,
   input logic            op_illegal,
   input logic [1:0]      op_fmt,
   input logic            op_sat,
   input logic [FLEN-1:0] scal_in,
   input logic [15:0]     scal_out
);

   assert_flag_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bad == cfg_q[XLEN-1]);

   assert_rsv_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_data[8] && (cfg_wr_data[5:3] >= 3'd2))
      |=> (cfg_bad && (cfg_q[XLEN-2:0] == '0)));

   assert_bad_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bad && op_valid) |-> op_illegal);

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!op_illegal && (op_fmt == 2'd0) && !op_sat));

   assert_no_bf16_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_illegal && !cfg_q[8]) |-> (op_fmt != 2'd1));

   assert_e5m2_needs_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_illegal && (op_fmt == 2'd3)) |-> cfg_q[8]);

   assert_sat_is_8bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op_sat |-> (!op_illegal && op_fmt[1]));

   assert_box_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (&scal_in[FLEN-1:16]) |-> (scal_out == scal_in[15:0]));

   assert_box_nan_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(&scal_in[FLEN-1:16]) |->
         (scal_out == (cfg_q[8] ? 16'h7FC0 : 16'h7E00)));

endmodule

bind vfmt_legality vfmt_legality_chk #(.XLEN(XLEN), .FLEN(FLEN)) chk_i (.*);

// File: tb/vfmt_legality_tb_top.sv
module vfmt_legality_tb_top;
   import vfmt_pkg::*;

   localparam int XLEN = 64;
   localparam int FLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_wr_en = 1'b0;
   logic [XLEN-1:0] cfg_wr_data = '0;
   logic [XLEN-1:0] cfg_q;
   logic            cfg_bad;
   logic            op_valid = 1'b0;
   logic [5:0]      op_id = '0;
   logic [4:0]      op_vs1 = '0;
   logic            op_illegal;
   logic [1:0]      op_fmt;
   logic            op_sat;
   logic [FLEN-1:0] scal_in = '0;
   logic [15:0]     scal_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   vfmt_legality #(.XLEN(XLEN), .FLEN(FLEN)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr_en (cfg_wr_en), .cfg_wr_data (cfg_wr_data),
      .cfg_q (cfg_q), .cfg_bad (cfg_bad),
      .op_valid (op_valid), .op_id (op_id), .op_vs1 (op_vs1),
      .op_illegal (op_illegal), .op_fmt (op_fmt), .op_sat (op_sat),
      .scal_in (scal_in), .scal_out (scal_out)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic write_cfg(logic [2:0] sew, logic alt, logic [2:0] lmul,
                            logic ta, logic ma, logic [XLEN-1:0] extra);
      logic [XLEN-1:0] d;
      d      = extra;
      d[2:0] = lmul;
      d[5:3] = sew;
      d[6]   = ta;
      d[7]   = ma;
      d[8]   = alt;
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
      #2;
   endtask

   task automatic chk_op(string tag, int id, logic [4:0] vs1,
                         logic ill, logic [1:0] fmt, logic sat);
      @(negedge clk);
      op_valid = 1'b1;
      op_id    = 6'(id);
      op_vs1   = vs1;
      #2;
      chk({tag, " illegal"}, 64'(op_illegal), 64'(ill));
      chk({tag, " fmt"},     64'(op_fmt),     64'(fmt));
      chk({tag, " sat"},     64'(op_sat),     64'(sat));
      op_valid = 1'b0;
   endtask

   function automatic bit in_bf16_16(int i);
      case (i)
         OP_ADD, OP_SUB, OP_MINMAX, OP_SGNJ, OP_SLIDE1, OP_SPLAT, OP_MERGE,
         OP_CMP, OP_MUL, OP_RSUB, OP_FMA, OP_WADDSUB, OP_WMUL, OP_WFMA,
         OP_MV_TO_ELEM, OP_MV_TO_SCAL, OP_WCVT_FF, OP_NCVT_FF, OP_NCVT_ROD,
         OP_RSQRT_EST, OP_RECIP_EST, OP_CLASS, OP_WMACC_BF, OP_WCVT_BF,
         OP_NCVT_BF: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic t_reset();
      chk("R1 reset cfg_q", cfg_q, 64'h8000_0000_0000_0000);
      chk("R1 reset cfg_bad", 64'(cfg_bad), 64'd1);
      chk_op("R3 op after reset", OP_ADD, 5'd0, 1'b1, 2'd0, 1'b0);
   endtask

   task automatic t_native();
      write_cfg(3'd1, 1'b0, 3'd1, 1'b1, 1'b0, '0);
      chk("R1 stored e16", cfg_q, 64'h0000_0000_0000_0049);
      chk("R1 bad clear", 64'(cfg_bad), 64'd0);
      for (int i = 0; i <= 30; i++) begin
         if (i == OP_NCVT_FF || i == OP_NCVT_BF) continue;
         chk_op("R5 native class", i, 5'd0, 1'b0, 2'd0, 1'b0);
      end
      @(negedge clk);
      op_valid = 1'b0; op_id = 6'(OP_DIV); #2;
      chk("R4 idle illegal", 64'(op_illegal), 64'd0);
      chk("R4 idle fmt", 64'(op_fmt), 64'd0);
      chk_op("R10 quad code at e16", OP_NCVT_FF, 5'b11001, 1'b1, 2'd0, 1'b0);
      chk_op("R3 unknown code", 40, 5'd0, 1'b1, 2'd0, 1'b0);
      scal_in = 64'hFFFF_FFFF_FFFF_3C00; #2;
      chk("R11 boxed passthru", 64'(scal_out), 64'h3C00);
      scal_in = 64'h0000_0000_0000_3C00; #2;
      chk("R11 fp16 nan", 64'(scal_out), 64'h7E00);
   endtask

   task automatic t_alt16();
      write_cfg(3'd1, 1'b1, 3'd0, 1'b0, 1'b1, '0);
      chk("R1 stored e16 alt", cfg_q, 64'h0000_0000_0000_0188);
      for (int i = 0; i <= 30; i++) begin
         if (in_bf16_16(i)) chk_op("R7 bf16 class", i, 5'd0, 1'b0, 2'd1, 1'b0);
         else               chk_op("R7 reserved class", i, 5'd0, 1'b1, 2'd0, 1'b0);
      end
      chk_op("R10 quad sat at e16", OP_NCVT_FF, 5'b11011, 1'b1, 2'd0, 1'b0);
      chk_op("R10 bf sat at e16", OP_NCVT_BF, 5'b11111, 1'b1, 2'd0, 1'b0);
      scal_in = 64'hFFFF_FFFF_FFFE_4000; #2;
      chk("R11 bf16 nan", 64'(scal_out), 64'h7FC0);
      scal_in = 64'hFFFF_FFFF_FFFF_4000; #2;
      chk("R11 boxed alt", 64'(scal_out), 64'h4000);
   endtask

   task automatic t_alt8();
      write_cfg(3'd0, 1'b1, 3'd2, 1'b1, 1'b1, '0);
      chk("R1 stored e8 alt", cfg_q, 64'h0000_0000_0000_01C2);
      for (int i = 0; i <= 30; i++) begin
         if (i == OP_WCVT_IF || i == OP_NCVT_FI)
            chk_op("R6 int8 bf16", i, 5'd0, 1'b0, 2'd1, 1'b0);
         else if (i == OP_WCVT_BF || i == OP_NCVT_BF)
            chk_op("R8 e5m2 form", i, 5'd0, 1'b0, 2'd3, 1'b0);
         else
            chk_op("R6 reserved at e8", i, 5'd0, 1'b1, 2'd0, 1'b0);
      end
      chk_op("R8 R9 quad sat e5m2", OP_NCVT_FF, 5'b11011, 1'b0, 2'd3, 1'b1);
      chk_op("R8 R9 quad plain e5m2", OP_NCVT_FF, 5'b11001, 1'b0, 2'd3, 1'b0);
      chk_op("R9 bf sat e5m2", OP_NCVT_BF, 5'b11111, 1'b0, 2'd3, 1'b1);
   endtask

   task automatic t_e4m3();
      write_cfg(3'd0, 1'b0, 3'd0, 1'b0, 1'b0, '0);
      chk_op("R8 widen e4m3", OP_WCVT_BF, 5'd0, 1'b0, 2'd2, 1'b0);
      chk_op("R8 R9 quad plain e4m3", OP_NCVT_FF, 5'b11001, 1'b0, 2'd2, 1'b0);
      chk_op("R9 quad sat e4m3", OP_NCVT_FF, 5'b11011, 1'b0, 2'd2, 1'b1);
      chk_op("R9 bf sat e4m3", OP_NCVT_BF, 5'b11111, 1'b0, 2'd2, 1'b1);
      chk_op("R9 bf plain e4m3", OP_NCVT_BF, 5'b00000, 1'b0, 2'd2, 1'b0);
      chk_op("R5 add at e8", OP_ADD, 5'd0, 1'b0, 2'd0, 1'b0);
   endtask

   task automatic t_rsv_cfg();
      write_cfg(3'd2, 1'b1, 3'd0, 1'b0, 1'b0, '0);
      chk("R2 alt e32 cfg_q", cfg_q, 64'h8000_0000_0000_0000);
      chk("R2 alt e32 bad", 64'(cfg_bad), 64'd1);
      chk_op("R3 op under bad cfg", OP_WCVT_IF, 5'd0, 1'b1, 2'd0, 1'b0);
      write_cfg(3'd2, 1'b0, 3'd3, 1'b0, 1'b0, '0);
      chk("R1 e32 plain ok", cfg_q, 64'h0000_0000_0000_0013);
      chk_op("R5 mul at e32", OP_MUL, 5'd0, 1'b0, 2'd0, 1'b0);
      write_cfg(3'd3, 1'b1, 3'd0, 1'b0, 1'b0, '0);
      chk("R2 alt e64 bad", 64'(cfg_bad), 64'd1);
      write_cfg(3'd5, 1'b0, 3'd0, 1'b0, 1'b0, '0);
      chk("R2 wide code bad", 64'(cfg_bad), 64'd1);
      write_cfg(3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 64'h0000_0000_0010_0000);
      chk("R2 upper bit bad", cfg_q, 64'h8000_0000_0000_0000);
      write_cfg(3'd1, 1'b1, 3'd0, 1'b0, 1'b0, '0);
      chk("R1 recover", 64'(cfg_bad), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      t_reset();
      t_native();
      t_alt16();
      t_alt8();
      t_e4m3();
      t_rsv_cfg();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule